// File: doc/BRIEF.md
# Descriptor chain queue manager

This engine owns one linked queue of 20-byte DMA descriptors held in a word-addressed SRAM. It keeps a head pointer and compares it against a fixed terminator descriptor address; the queue is empty exactly when the two are equal. A packet is a chain of one or more descriptors. The first descriptor of a packet points at the packet's final descriptor, and that final descriptor's next pointer leads to the following packet. Because of this, a whole packet is unlinked in one operation.

A client issues commands over a valid/busy handshake and receives one response pulse per command. The commands are:

- load the head pointer;
- dequeue one packet when the head's ownership code matches a requested value;
- dequeue one packet when the head's ownership code differs from a requested value;
- count every subdescriptor up to the terminator;
- hand a descriptor back to hardware ownership;
- reinitialise a descriptor as an empty receive buffer.

All descriptor traffic uses a simple synchronous memory port with one cycle of read latency.

Top module: `dq_chain_engine`

## Requirements
- R1: After reset, busy and rsp_valid are low and the head equals the terminator. A dequeue then returns null and a count returns 0.
- R2: Pointers are byte addresses, and word i of the descriptor at pointer p sits at word address p/4 + i. Word 0 is {control, status}. Word 1 is {total length, data size}. Word 2 is the last-descriptor pointer, word 3 is the data pointer, and word 4 is the next pointer. Ownership is status bits [1:0], with 0 = software, 1 = hardware and 2 = special.
- R3: A dequeue while the head equals the terminator returns rsp_null=1 and leaves the head unchanged.
- R4: A match dequeue (cmd_op 1) returns the head in rsp_ptr only if its ownership equals cmd_code. Otherwise it returns rsp_null=1 and the head is unchanged.
- R5: A mismatch dequeue (cmd_op 2) returns the head only if its ownership differs from cmd_code. Otherwise it returns rsp_null=1 and the head is unchanged.
- R6: After a successful dequeue, the new head is the next pointer of the descriptor named by the old head's last pointer, so a multi-descriptor packet leaves as a unit.
- R7: A count (cmd_op 3) follows next pointers from the head up to the terminator. It reports every subdescriptor in rsp_count with rsp_err=0.
- R8: A count that takes MAX_STEPS steps without reaching the terminator stops with rsp_err=1 and rsp_count=MAX_STEPS. A chain of exactly MAX_STEPS descriptors reports no error.
- R9: Rearm (cmd_op 4, descriptor at cmd_ptr) sets ownership to 1. All other status bits, the control field and the other words are preserved.
- R10: Receive reset (cmd_op 5, descriptor at cmd_ptr) writes word 0 = 0x00000001 and word 1 = {RX_BLOCK_LEN, 0}, where the default RX_BLOCK_LEN is 320. It writes word 2 = the descriptor's own address and leaves words 3 and 4 untouched.
- R11: Command codes are 0 load head, 1 match dequeue, 2 mismatch dequeue, 3 count, 4 rearm and 5 receive reset. A command is taken only on a clock where cmd_valid is high and busy is low. busy stays high from that clock until the response, and rsp_valid is a single-cycle pulse given while busy. cmd_valid seen while busy, including the response cycle, is ignored.
- R12: Load head (cmd_op 0) sets the head to cmd_ptr and echoes cmd_ptr in rsp_ptr.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 3 | Command code |
| cmd_code | input | 2 | Ownership code for dequeue |
| cmd_ptr | input | ADDR_W | Descriptor address for load, rearm, receive reset |
| busy | output | 1 | Command in progress |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_null | output | 1 | Dequeue found nothing |
| rsp_err | output | 1 | Count hit the step limit |
| rsp_ptr | output | ADDR_W | Dequeued or addressed descriptor |
| rsp_count | output | CNT_W | Subdescriptor count |
| mem_en | output | 1 | Memory access strobe |
| mem_we | output | 1 | Memory write |
| mem_addr | output | ADDR_W-2 | Word address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, one cycle after a read |

## Verification
Two things can land in the same cycle: the response pulse of one command and the arrival of the next command. The bench drives cmd_valid on exactly the cycle where rsp_valid is high, then drops it one cycle later. It judges the collision by checking that busy is low and rsp_valid has fallen in that following cycle. It then counts the queue again to confirm that the ignored load-head command did not move the head. A second collision is the step limit coinciding with the terminator. A chain of exactly MAX_STEPS descriptors must report a clean count, while one descriptor more must report the error.

// File: rtl/dq_pkg.sv
// Shared definitions for the descriptor chain queue manager.
// Assumes 32-bit descriptor words, five words per descriptor.
package dq_pkg;
    typedef enum logic [2:0] {
        OP_SET_HEAD = 3'd0,
        OP_DEQ_EQ   = 3'd1,
        OP_DEQ_NE   = 3'd2,
        OP_COUNT    = 3'd3,
        OP_REARM    = 3'd4,
        OP_RX_INIT  = 3'd5
    } dq_op_e;

    typedef enum logic [4:0] {
        S_IDLE, S_DQ_RS, S_DQ_WS, S_DQ_RL, S_DQ_WL, S_DQ_RN, S_DQ_WN,
        S_CN_TEST, S_CN_RD, S_CN_WT,
        S_RA_RD, S_RA_WT, S_RA_WR,
        S_RX_W0, S_RX_W1, S_RX_W2,
        S_DONE
    } dq_state_e;

    localparam logic [2:0] W_STATCTL = 3'd0;
    localparam logic [2:0] W_LENGTHS = 3'd1;
    localparam logic [2:0] W_LAST    = 3'd2;
    localparam logic [2:0] W_NEXT    = 3'd4;
    localparam logic [1:0] OWN_HW    = 2'b01;
endpackage

// File: rtl/dq_addr_gen.sv
// Forms the word address of one field of a descriptor.
// Assumes descriptor base pointers are 4-byte aligned byte addresses.
module dq_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [2:0]        word_idx,
    output logic [ADDR_W-3:0] word_addr
);
    localparam int WA_W = ADDR_W - 2;

    // Base word index plus field offset.
    always_comb begin
        word_addr = base[ADDR_W-1:2] + WA_W'(word_idx);
    end
endmodule

// File: rtl/dq_own_check.sv
// Decides whether a head descriptor may be taken, given its ownership
// code, the requested code and whether the test is inverted.
module dq_own_check (
    input  logic [1:0] own,
    input  logic [1:0] code,
    input  logic       invert,
    output logic       take
);
    // Equality test, optionally inverted for mismatch dequeue.
    always_comb begin
        take = (own == code) ^ invert;
    end
endmodule

// File: rtl/dq_chain_engine.sv
// Descriptor chain queue manager. Holds a head pointer against a fixed
// terminator address and walks descriptor chains in an external SRAM.
// Assumes a synchronous memory with one cycle of read latency and
// ADDR_W no wider than 32.
module dq_chain_engine
    import dq_pkg::*;
#(
    parameter int          ADDR_W       = 32,
    parameter logic [31:0] TERM_PTR     = 32'h0,
    parameter int          MAX_STEPS    = 1024,
    parameter int          RX_BLOCK_LEN = 320,
    localparam int         CNT_W        = $clog2(MAX_STEPS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [2:0]        cmd_op,
    input  logic [1:0]        cmd_code,
    input  logic [ADDR_W-1:0] cmd_ptr,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_null,
    output logic              rsp_err,
    output logic [ADDR_W-1:0] rsp_ptr,
    output logic [CNT_W-1:0]  rsp_count,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-3:0] mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata
);
    localparam logic [ADDR_W-1:0] TERM  = TERM_PTR[ADDR_W-1:0];
    localparam logic [CNT_W-1:0]  LIMIT = CNT_W'(MAX_STEPS);

    dq_state_e         state_q;
    dq_op_e            op_q;
    logic [1:0]        code_q;
    logic [ADDR_W-1:0] head_q;
    logic [ADDR_W-1:0] walk_q;
    logic [31:0]       hold_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              null_q;
    logic              err_q;
    logic [ADDR_W-1:0] ptr_q;

    logic [ADDR_W-1:0] ag_base;
    logic [2:0]        ag_idx;
    logic              take;

    dq_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .base      (ag_base),
        .word_idx  (ag_idx),
        .word_addr (mem_addr)
    );

    dq_own_check u_own (
        .own    (mem_rdata[1:0]),
        .code   (code_q),
        .invert (op_q == OP_DEQ_NE),
        .take   (take)
    );

    // Memory request decode from the current state.
    always_comb begin
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        ag_base   = walk_q;
        ag_idx    = W_STATCTL;
        mem_wdata = 32'h0;
        case (state_q)
            S_DQ_RS: begin mem_en = 1'b1; ag_base = head_q; end
            S_DQ_RL: begin mem_en = 1'b1; ag_base = head_q; ag_idx = W_LAST; end
            S_DQ_RN, S_CN_RD: begin mem_en = 1'b1; ag_idx = W_NEXT; end
            S_RA_RD: mem_en = 1'b1;
            S_RA_WR: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = hold_q; end
            S_RX_W0: begin mem_en = 1'b1; mem_we = 1'b1; mem_wdata = {30'h0, OWN_HW}; end
            S_RX_W1: begin
                mem_en = 1'b1; mem_we = 1'b1; ag_idx = W_LENGTHS;
                mem_wdata = {16'(RX_BLOCK_LEN), 16'h0};
            end
            S_RX_W2: begin
                mem_en = 1'b1; mem_we = 1'b1; ag_idx = W_LAST;
                mem_wdata = 32'(walk_q);
            end
            default: ;
        endcase
    end

    // Command sequencer and queue state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            op_q    <= OP_SET_HEAD;
            code_q  <= 2'b00;
            head_q  <= TERM;
            walk_q  <= TERM;
            hold_q  <= 32'h0;
            cnt_q   <= '0;
            null_q  <= 1'b0;
            err_q   <= 1'b0;
            ptr_q   <= '0;
        end else begin
            case (state_q)
                S_IDLE: if (cmd_valid) begin
                    op_q   <= dq_op_e'(cmd_op);
                    code_q <= cmd_code;
                    null_q <= 1'b0;
                    err_q  <= 1'b0;
                    cnt_q  <= '0;
                    ptr_q  <= '0;
                    walk_q <= cmd_ptr;
                    case (dq_op_e'(cmd_op))
                        OP_SET_HEAD: begin head_q <= cmd_ptr; ptr_q <= cmd_ptr; state_q <= S_DONE; end
                        OP_DEQ_EQ, OP_DEQ_NE: begin
                            if (head_q == TERM) begin
                                null_q  <= 1'b1;
                                state_q <= S_DONE;
                            end else begin
                                state_q <= S_DQ_RS;
                            end
                        end
                        OP_COUNT:   begin walk_q <= head_q; state_q <= S_CN_TEST; end
                        OP_REARM:   state_q <= S_RA_RD;
                        OP_RX_INIT: state_q <= S_RX_W0;
                        default:    begin null_q <= 1'b1; state_q <= S_DONE; end
                    endcase
                end
                S_DQ_RS: state_q <= S_DQ_WS;
                S_DQ_WS: begin
                    if (take) begin
                        state_q <= S_DQ_RL;
                    end else begin
                        null_q  <= 1'b1;
                        state_q <= S_DONE;
                    end
                end
                S_DQ_RL: state_q <= S_DQ_WL;
                S_DQ_WL: begin walk_q <= mem_rdata[ADDR_W-1:0]; state_q <= S_DQ_RN; end
                S_DQ_RN: state_q <= S_DQ_WN;
                S_DQ_WN: begin
                    ptr_q   <= head_q;
                    head_q  <= mem_rdata[ADDR_W-1:0];
                    state_q <= S_DONE;
                end
                S_CN_TEST: begin
                    if (walk_q == TERM) begin
                        state_q <= S_DONE;
                    end else if (cnt_q == LIMIT) begin
                        err_q   <= 1'b1;
                        state_q <= S_DONE;
                    end else begin
                        state_q <= S_CN_RD;
                    end
                end
                S_CN_RD: state_q <= S_CN_WT;
                S_CN_WT: begin
                    walk_q  <= mem_rdata[ADDR_W-1:0];
                    cnt_q   <= cnt_q + 1'b1;
                    state_q <= S_CN_TEST;
                end
                S_RA_RD: state_q <= S_RA_WT;
                S_RA_WT: begin hold_q <= {mem_rdata[31:2], OWN_HW}; state_q <= S_RA_WR; end
                S_RA_WR: begin ptr_q <= walk_q; state_q <= S_DONE; end
                S_RX_W0: state_q <= S_RX_W1;
                S_RX_W1: state_q <= S_RX_W2;
                S_RX_W2: begin ptr_q <= walk_q; state_q <= S_DONE; end
                S_DONE:  state_q <= S_IDLE;
                default: state_q <= S_IDLE;
            endcase
        end
    end

    // Response and status outputs.
    always_comb begin
        busy      = (state_q != S_IDLE);
        rsp_valid = (state_q == S_DONE);
        rsp_null  = null_q;
        rsp_err   = err_q;
        rsp_ptr   = ptr_q;
        rsp_count = cnt_q;
    end
endmodule

// File: rtl/dq_chain_engine_chk.sv
// Protocol and update checks for dq_chain_engine, bound to every instance.
module dq_chain_engine_chk #(
    parameter int ADDR_W    = 32,
    parameter int CNT_W     = 11,
    parameter int MAX_STEPS = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              rsp_valid,
    input logic              rsp_null,
    input logic              rsp_err,
    input logic [CNT_W-1:0]  rsp_count,
    input logic              mem_we,
    input logic [1:0]        wdata_own,
    input logic              in_rearm,
    input logic [ADDR_W-1:0] head_q
);
    AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R11
    AST_RSP_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> busy); // R11
    AST_ACCEPT_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !busy) |=> busy); // R11
    AST_NULL_KEEPS_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_null) |-> $stable(head_q)); // R4
    AST_LIMIT_AT_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err) |-> (rsp_count == CNT_W'(MAX_STEPS))); // R8
    AST_REARM_TO_HW: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && in_rearm) |-> (wdata_own == 2'b01)); // R9
endmodule

bind dq_chain_engine dq_chain_engine_chk #(
    .ADDR_W(ADDR_W), .CNT_W(CNT_W), .MAX_STEPS(MAX_STEPS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .busy      (busy),
    .rsp_valid (rsp_valid),
    .rsp_null  (rsp_null),
    .rsp_err   (rsp_err),
    .rsp_count (rsp_count),
    .mem_we    (mem_we),
    .wdata_own (mem_wdata[1:0]),
    .in_rearm  (state_q == dq_pkg::S_RA_WR),
    .head_q    (head_q)
);

// File: tb/dq_chain_engine_test.sv
`timescale 1ns/1ps
// Directed bench for dq_chain_engine with a 256-word SRAM model.
module dq_chain_engine_test;
    localparam int AW    = 32;
    localparam int MAXS  = 6;
    localparam int CW    = $clog2(MAXS + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_valid = 1'b0;
    logic [2:0]    cmd_op = 3'd0;
    logic [1:0]    cmd_code = 2'd0;
    logic [AW-1:0] cmd_ptr = '0;
    logic          busy, rsp_valid, rsp_null, rsp_err;
    logic [AW-1:0] rsp_ptr;
    logic [CW-1:0] rsp_count;
    logic          mem_en, mem_we;
    logic [AW-3:0] mem_addr;
    logic [31:0]   mem_wdata;
    logic [31:0]   mem_rdata = 32'h0;

    logic [31:0]   mem [256];
    logic          tb_we = 1'b0;
    logic [7:0]    tb_addr = 8'd0;
    logic [31:0]   tb_data = 32'h0;

    int n_checks = 0;
    int n_fail = 0;
    logic          r_null, r_err;
    logic [AW-1:0] r_ptr;
    logic [CW-1:0] r_cnt;

    always #10 clk = ~clk;

    dq_chain_engine #(.ADDR_W(AW), .TERM_PTR(32'h0), .MAX_STEPS(MAXS)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_code(cmd_code), .cmd_ptr(cmd_ptr), .busy(busy),
        .rsp_valid(rsp_valid), .rsp_null(rsp_null), .rsp_err(rsp_err),
        .rsp_ptr(rsp_ptr), .rsp_count(rsp_count), .mem_en(mem_en),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );

    // SRAM model: engine port and bench preload port.
    always @(posedge clk) begin
        if (tb_we) mem[tb_addr] <= tb_data;
        if (mem_en) begin
            if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
            mem_rdata <= mem[mem_addr[7:0]];
        end
    end

    function automatic logic [31:0] dp(input int k);
        return 32'(20 * k);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic poke(input int widx, input logic [31:0] d);
        @(negedge clk);
        tb_we = 1'b1; tb_addr = 8'(widx); tb_data = d;
        @(negedge clk);
        tb_we = 1'b0;
    endtask

    task automatic put_desc(input int k, input logic [15:0] stat, input logic [15:0] ctl,
                            input int last_k, input int next_k);
        poke(5*k + 0, {ctl, stat});
        poke(5*k + 1, 32'h0140_0000);
        poke(5*k + 2, dp(last_k));
        poke(5*k + 3, 32'hDA7A_0000 + 32'(k));
        poke(5*k + 4, dp(next_k));
    endtask

    task automatic run(input logic [2:0] op, input logic [1:0] code, input logic [AW-1:0] ptr);
        int waited = 0;
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_code = code; cmd_ptr = ptr;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!rsp_valid && waited < 200) begin
            @(negedge clk);
            waited++;
        end
        if (!rsp_valid) begin
            n_checks++; n_fail++;
            $display("FAIL R11 actual=no response expected=response");
        end
        r_null = rsp_null; r_err = rsp_err; r_ptr = rsp_ptr; r_cnt = rsp_count;
    endtask

    task automatic t_reset;
        check("R1 busy", 32'(busy), 32'd0);
        check("R1 rsp_valid", 32'(rsp_valid), 32'd0);
        run(3'd1, 2'd0, '0);
        check("R1 R3 empty dequeue null", 32'(r_null), 32'd1);
        run(3'd3, 2'd0, '0);
        check("R1 empty count", 32'(r_cnt), 32'd0);
    endtask

    task automatic t_dequeue;
        put_desc(1, 16'h0000, 16'h0200, 2, 2);
        put_desc(2, 16'h0000, 16'h0100, 2, 3);
        put_desc(3, 16'h0001, 16'h0300, 3, 4);
        put_desc(4, 16'h0000, 16'h0300, 4, 0);
        run(3'd0, 2'd0, dp(1));
        check("R12 load head echo", r_ptr, dp(1));
        run(3'd3, 2'd0, '0);
        check("R7 subdescriptor count", 32'(r_cnt), 32'd4);
        check("R7 no error", 32'(r_err), 32'd0);
        run(3'd1, 2'd0, '0);
        check("R4 match returns head", r_ptr, dp(1));
        check("R4 match not null", 32'(r_null), 32'd0);
        run(3'd3, 2'd0, '0);
        check("R6 packet removed as unit", 32'(r_cnt), 32'd2);
        run(3'd1, 2'd0, '0);
        check("R4 hw-owned head gives null", 32'(r_null), 32'd1);
        run(3'd2, 2'd0, '0);
        check("R5 mismatch returns head", r_ptr, dp(3));
        run(3'd2, 2'd0, '0);
        check("R5 equal code gives null", 32'(r_null), 32'd1);
        run(3'd1, 2'd0, '0);
        check("R6 head advanced to d4", r_ptr, dp(4));
        run(3'd1, 2'd0, '0);
        check("R3 drained queue null", 32'(r_null), 32'd1);
    endtask

    task automatic t_rearm;
        poke(25, {16'h0300, 16'hABC2});
        poke(26, 32'h1234_5678);
        run(3'd4, 2'd0, dp(5));
        check("R9 rearm ptr", r_ptr, dp(5));
        check("R9 status and control", mem[25], {16'h0300, 16'hABC1});
        check("R9 lengths untouched", mem[26], 32'h1234_5678);
    endtask

    task automatic t_rxinit;
        put_desc(6, 16'hFFFE, 16'hFFFF, 9, 7);
        poke(31, 32'h5555_AAAA);
        run(3'd5, 2'd0, dp(6));
        check("R10 R2 word0", mem[30], 32'h0000_0001);
        check("R10 R2 word1 length", mem[31], 32'h0140_0000);
        check("R10 R2 word2 self", mem[32], dp(6));
        check("R10 word3 untouched", mem[33], 32'hDA7A_0006);
        check("R10 word4 untouched", mem[34], dp(7));
    endtask

    task automatic t_limit;
        for (int k = 10; k < 16; k++) put_desc(k, 16'h0, 16'h0, k, (k == 15) ? 0 : k + 1);
        run(3'd0, 2'd0, dp(10));
        run(3'd3, 2'd0, '0);
        check("R8 exact limit count", 32'(r_cnt), 32'd6);
        check("R8 exact limit no error", 32'(r_err), 32'd0);
        poke(5*15 + 4, dp(16));
        put_desc(16, 16'h0, 16'h0, 16, 0);
        run(3'd3, 2'd0, '0);
        check("R8 overlong error", 32'(r_err), 32'd1);
        check("R8 overlong count", 32'(r_cnt), 32'd6);
    endtask

    task automatic t_collide;
        put_desc(20, 16'h0, 16'h0, 20, 21);
        put_desc(21, 16'h0, 16'h0, 21, 0);
        run(3'd0, 2'd0, dp(20));
        cmd_valid = 1'b1; cmd_op = 3'd0; cmd_ptr = dp(1);
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R11 response is one pulse", 32'(rsp_valid), 32'd0);
        check("R11 command in response cycle ignored", 32'(busy), 32'd0);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = 3'd3;
        @(negedge clk);
        cmd_op = 3'd0; cmd_ptr = dp(1);
        @(negedge clk);
        check("R11 busy during command", 32'(busy), 32'd1);
        cmd_valid = 1'b0;
        while (!rsp_valid) @(negedge clk);
        check("R11 count unaffected", 32'(rsp_count), 32'd2);
        run(3'd3, 2'd0, '0);
        check("R11 head unchanged", 32'(r_cnt), 32'd2);
    endtask

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_dequeue();
        t_rearm();
        t_rxinit();
        t_limit();
        t_collide();
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule